// File: doc/BRIEF.md
# Counted Configuration Clock Burst Generator

This block drives a configuration clock pin in bursts of a set length. Software writes a pulse count into a count register. The block then toggles its clock output exactly that many times and stops with the pin low. When the last pulse has ended, a sticky done flag in the status register goes high. Software clears that flag by writing a one to it, both before a burst is started and after it has been seen.

Each pulse is a high phase followed by a low phase. Each phase lasts one tick of a divider, and the divider ticks once every `clk_div + 1` system clock cycles. The divider setting is taken when a burst starts, so the pulse width stays the same for the whole burst. The register port is a simple 32-bit bus with byte addresses, a 4-byte stride, separate read and write strobes, and read data that is registered one cycle after the read strobe.

Top module: `cfgclk_burst_gen`

## Requirements
- R1: After reset `cfg_clk` is low, and both the status register and the count register read as 0.
- R2: A write of N (N > 0, low CNT_W bits of the data) to byte offset 0x08 while no burst runs starts a burst of exactly N pulses. With divider setting D, counting edges from the capturing write edge, `cfg_clk` is high after edge k exactly when floor(k/(D+1)) is odd, for k < 2·N·(D+1).
- R3: Status bit 0 (offset 0x0C) becomes 1 at edge 2·N·(D+1) after the starting write, the same edge at which the last pulse falls, and not earlier.
- R4: A status write with data bit 0 = 1 clears the done flag. A status write with bit 0 = 0 leaves the flag unchanged, whatever the other data bits are.
- R5: A count write during a burst is ignored: the burst keeps its original pulse count and timing, and the count register keeps reading the original count.
- R6: A count of 0 sets the done flag at the capturing write edge and emits no pulse.
- R7: Reads return, one cycle after the read strobe, the last accepted count at 0x08 (zero-extended) and the done flag in bit 0 at 0x0C with the other bits 0. Every other offset reads 0, and writes to other offsets have no effect.
- R8: `cfg_clk` is low whenever no burst is running.
- R9: The divider setting is taken at the burst start. Changing `clk_div` during a burst does not change that burst's timing.
- R10: With D = 0, a burst of 0x7FF pulses completes in 4094 cycles, inside a 100 µs window at a 50 MHz clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | Divider setting D; each phase lasts D+1 cycles |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered one cycle after `bus_rd` |
| cfg_clk | output | 1 | Configuration clock output |

## Verification
The bench follows the output waveform cycle by cycle for several divider settings. It reads the status register on the last cycle before completion and again on the completion cycle, so a done flag that comes one cycle early or late, or a burst with one pulse too many or too few, shows up as a wrong read. A count write in the middle of a burst would otherwise restart or lengthen it. A divider change in the middle of a burst would otherwise stretch later phases. A zero count would otherwise leave the flag clear or emit a pulse that should not be there. Status writes are made with bit 0 clear and the upper bits set, to catch a clear that decodes the wrong bit, and unmapped offsets are read to catch aliasing in the register decode.

// File: rtl/cfgclk_pkg.sv
package cfgclk_pkg;

  localparam int unsigned REG_STRIDE = 4;
  localparam int unsigned OFS_COUNT  = 'h08;
  localparam int unsigned OFS_STATUS = 'h0C;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOW  = 2'd1,
    SEQ_HIGH = 2'd2
  } seq_state_e;

  // Cycles in one phase (high or low) for a divider setting.
  function automatic int unsigned phase_cycles(input int unsigned div);
    return div + 1;
  endfunction

  // Cycles from the capturing write edge to the edge that sets done.
  function automatic int unsigned burst_cycles(input int unsigned n,
                                               input int unsigned div);
    return 2 * n * phase_cycles(div);
  endfunction

  function automatic int unsigned word_index(input int unsigned byte_ofs);
    return byte_ofs / REG_STRIDE;
  endfunction

endpackage

// File: rtl/cfgclk_divider.sv
module cfgclk_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/cfgclk_pulse_seq.sv
module cfgclk_pulse_seq
  import cfgclk_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ev,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic [DIV_W-1:0] div_in,
  input  logic             tick,
  output logic             busy,
  output logic             cfg_clk,
  output logic             finish_ev,
  output logic [DIV_W-1:0] div_q,
  output logic [CNT_W-1:0] remaining
);

  seq_state_e state_q;

  assign busy      = (state_q != SEQ_IDLE);
  assign cfg_clk   = (state_q == SEQ_HIGH);
  assign finish_ev = (state_q == SEQ_HIGH) && tick && (remaining == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      remaining <= '0;
      div_q     <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_ev) begin
            state_q   <= SEQ_LOW;
            remaining <= start_cnt;
            div_q     <= div_in;
          end
        end
        SEQ_LOW: begin
          if (tick) state_q <= SEQ_HIGH;
        end
        SEQ_HIGH: begin
          if (tick) begin
            remaining <= remaining - CNT_W'(1);
            state_q   <= finish_ev ? SEQ_IDLE : SEQ_LOW;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfgclk_regs.sv
module cfgclk_regs
  import cfgclk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              finish_ev,
  output logic              start_ev,
  output logic              zero_ev,
  output logic              drop_ev,
  output logic              clr_ev,
  output logic [CNT_W-1:0]  count_q,
  output logic              done_q
);

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] COUNT_IDX  = IDX_W'(word_index(OFS_COUNT));
  localparam logic [IDX_W-1:0] STATUS_IDX = IDX_W'(word_index(OFS_STATUS));

  logic [IDX_W-1:0] widx;
  logic             count_wr;
  logic             status_wr;
  logic [CNT_W-1:0] wcount;
  logic             unused_bits;

  assign widx        = bus_addr[ADDR_W-1:2];
  assign wcount      = bus_wdata[CNT_W-1:0];
  assign unused_bits = ^{bus_wdata[DATA_W-1:CNT_W], bus_addr[1:0]};

  assign count_wr  = bus_wr && (widx == COUNT_IDX);
  assign status_wr = bus_wr && (widx == STATUS_IDX);
  assign start_ev  = count_wr && !busy && (wcount != '0);
  assign zero_ev   = count_wr && !busy && (wcount == '0);
  assign drop_ev   = count_wr && busy;
  assign clr_ev    = status_wr && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (count_wr && !busy) count_q <= wcount;
      if (finish_ev || zero_ev) begin
        done_q <= 1'b1;
      end else if (clr_ev) begin
        done_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (widx == COUNT_IDX) begin
        bus_rdata <= {{(DATA_W-CNT_W){1'b0}}, count_q};
      end else if (widx == STATUS_IDX) begin
        bus_rdata <= {{(DATA_W-1){1'b0}}, done_q};
      end else begin
        bus_rdata <= '0;
      end
    end
  end

endmodule

// File: rtl/cfgclk_burst_gen.sv
module cfgclk_burst_gen #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              cfg_clk
);

  logic             busy;
  logic             tick;
  logic             start_ev;
  logic             zero_ev;
  logic             drop_ev;
  logic             clr_ev;
  logic             finish_ev;
  logic             done_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] remaining;
  logic [DIV_W-1:0] div_q;

  cfgclk_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(32),
    .CNT_W (CNT_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .busy     (busy),
    .finish_ev(finish_ev),
    .start_ev (start_ev),
    .zero_ev  (zero_ev),
    .drop_ev  (drop_ev),
    .clr_ev   (clr_ev),
    .count_q  (count_q),
    .done_q   (done_q)
  );

  cfgclk_divider #(
    .DIV_W(DIV_W)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .div_val(div_q),
    .tick   (tick)
  );

  cfgclk_pulse_seq #(
    .CNT_W(CNT_W),
    .DIV_W(DIV_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ev (start_ev),
    .start_cnt(bus_wdata[CNT_W-1:0]),
    .div_in   (clk_div),
    .tick     (tick),
    .busy     (busy),
    .cfg_clk  (cfg_clk),
    .finish_ev(finish_ev),
    .div_q    (div_q),
    .remaining(remaining)
  );

endmodule

// File: rtl/cfgclk_burst_gen_chk.sv
module cfgclk_burst_gen_chk
  import cfgclk_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_clk,
  input logic             busy,
  input logic             start_ev,
  input logic             zero_ev,
  input logic             drop_ev,
  input logic             clr_ev,
  input logic             finish_ev,
  input logic             done_q,
  input logic [CNT_W-1:0] count_q,
  input logic [DIV_W-1:0] div_q,
  input logic [CNT_W-1:0] remaining
);

  int unsigned elapsed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= 0;
    end else if (start_ev) begin
      elapsed <= 0;
    end else if (busy) begin
      elapsed <= elapsed + 1;
    end
  end

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cfg_clk);

  // R3
  done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish_ev |=> done_q);

  // R3
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish_ev |-> (elapsed + 1 == burst_cycles(32'(count_q), 32'(div_q))));

  // R6
  zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_ev |=> (done_q && !busy && !cfg_clk));

  // R5
  drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> $stable(count_q));

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !finish_ev && !zero_ev) |=> !done_q);

  // R9
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div_q));

  // R2
  pulse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cfg_clk) && $past(busy)) |-> (remaining == $past(remaining) - CNT_W'(1)));

endmodule

bind cfgclk_burst_gen cfgclk_burst_gen_chk #(
  .CNT_W(CNT_W),
  .DIV_W(DIV_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_clk  (cfg_clk),
  .busy     (busy),
  .start_ev (start_ev),
  .zero_ev  (zero_ev),
  .drop_ev  (drop_ev),
  .clr_ev   (clr_ev),
  .finish_ev(finish_ev),
  .done_q   (done_q),
  .count_q  (count_q),
  .div_q    (div_q),
  .remaining(remaining)
);

// File: tb/cfgclk_burst_gen_test.sv
module cfgclk_burst_gen_test;

  localparam logic [7:0] A_COUNT  = 8'h08;
  localparam logic [7:0] A_STATUS = 8'h0C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  clk_div = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        cfg_clk;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  cfgclk_burst_gen uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_div  (clk_div),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .cfg_clk  (cfg_clk)
  );

  task automatic check_eq(input string req, input string what,
                          input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // All bus tasks start and end on a falling edge.
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic run_burst(input string req, input int n, input int d,
                           input int mid_wr_k, input int mid_div_k);
    logic [31:0] rd;
    int k_end;
    int rises;
    int mism;
    logic prev;
    logic expv;
    clk_div = 8'(d);
    bus_write(A_STATUS, 32'h1);
    bus_write(A_COUNT, 32'(n));
    k_end = 2 * n * (d + 1);
    rises = 0; mism = 0; prev = cfg_clk;
    check_eq("R8", "cfg_clk low at burst start", cfg_clk, 0);
    for (int k = 1; k < k_end; k++) begin
      if (k - 1 == mid_wr_k) begin
        bus_addr = A_COUNT; bus_wdata = 32'd9; bus_wr = 1'b1;
      end else begin
        bus_wr = 1'b0;
      end
      if (k - 1 == mid_div_k) clk_div = 8'd0;
      @(negedge clk);
      expv = ((k / (d + 1)) % 2) == 1;
      if (cfg_clk !== expv) mism++;
      if (cfg_clk && !prev) rises++;
      prev = cfg_clk;
    end
    bus_wr = 1'b0;
    check_eq(req, "waveform mismatching cycles (R2)", mism, 0);
    check_eq(req, "pulse count (R2)", rises, n);
    bus_read(A_STATUS, rd);
    check_eq("R3", "done one cycle before completion", rd, 0);
    check_eq("R8", "cfg_clk low after last pulse", cfg_clk, 0);
    bus_read(A_STATUS, rd);
    check_eq("R3", "done at completion", rd, 1);
    bus_read(A_COUNT, rd);
    check_eq("R7", "count readback", rd, n);
  endtask

  task automatic t_reset();
    logic [31:0] rd;
    check_eq("R1", "cfg_clk after reset", cfg_clk, 0);
    bus_read(A_STATUS, rd);
    check_eq("R1", "status after reset", rd, 0);
    bus_read(A_COUNT, rd);
    check_eq("R1", "count after reset", rd, 0);
  endtask

  task automatic t_basic();
    run_burst("R2", 3, 0, -1, -1);
    run_burst("R2", 4, 3, -1, -1);
  endtask

  task automatic t_ignore_busy_write();
    run_burst("R5", 5, 1, 6, -1);
  endtask

  task automatic t_div_latch();
    run_burst("R9", 3, 2, -1, 4);
    clk_div = 8'd0;
  endtask

  task automatic t_zero();
    logic [31:0] rd;
    int highs;
    bus_write(A_STATUS, 32'h1);
    bus_write(A_COUNT, 32'h0);
    bus_read(A_STATUS, rd);
    check_eq("R6", "done right after zero count", rd, 1);
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cfg_clk) highs++;
    end
    check_eq("R6", "cycles high after zero count", highs, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] rd;
    bus_write(A_STATUS, 32'h0);
    bus_read(A_STATUS, rd);
    check_eq("R4", "done after writing 0", rd, 1);
    bus_write(A_STATUS, 32'hFFFF_FFFE);
    bus_read(A_STATUS, rd);
    check_eq("R4", "done after writing upper bits only", rd, 1);
    bus_write(A_STATUS, 32'h1);
    bus_read(A_STATUS, rd);
    check_eq("R4", "done after writing 1", rd, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] rd;
    int highs;
    bus_write(8'h10, 32'd5);
    bus_write(8'h00, 32'd7);
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cfg_clk) highs++;
    end
    check_eq("R7", "pulses after unmapped writes", highs, 0);
    bus_read(8'h00, rd);
    check_eq("R7", "read 0x00", rd, 0);
    bus_read(8'h04, rd);
    check_eq("R7", "read 0x04", rd, 0);
    bus_read(8'h10, rd);
    check_eq("R7", "read 0x10", rd, 0);
    bus_read(8'h3C, rd);
    check_eq("R7", "read 0x3C", rd, 0);
    bus_read(A_STATUS, rd);
    check_eq("R7", "status unchanged by unmapped writes", rd, 0);
  endtask

  task automatic t_long();
    check_eq("R10", "cycles for 0x7FF within 5000", (2 * 2047 <= 5000), 1);
    run_burst("R10", 2047, 0, -1, -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_basic();
        t_ignore_busy_write();
        t_div_latch();
        t_zero();
        t_w1c();
        t_unmapped();
        t_long();
      end
      begin
        repeat (100000) @(negedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule